// File: doc/BRIEF.md
# ECAM Configuration Access Decoder

This block sits between a root port's configuration request source and its enhanced configuration window. It takes one request at a time through a valid/ready handshake. The request carries a target bus, a device/function number, a register offset, a read/write flag, write data and the primary bus number of the target bus. The block checks the request against the root port's filtering rules. An access that passes is forwarded with its window address. An access that fails is answered at once with a reject flag, and a read that fails returns all ones.

An accepted access waits for a completion on a separate input. If no completion arrives within a parameterized number of cycles, the block ends the access with a rejected response. It also raises a one-cycle timeout event, meant to drive the configuration-timeout bit (bit 8) of an interrupt decode unit. A constant bridge information word reports the size field of the window, which is the last valid bus number.

Only one access is in flight at a time. Packet generation toward the link is left to the logic that consumes the forwarded address.

Top module: `ecam_cfg_decoder`

## Requirements
- R1: An accepted access drives `fwd_addr` = (bus << 20) | (devfn << 12) | register offset. The completed response returns the same value on `rsp_addr`.
- R2: While `link_up` is low, an access whose bus differs from `root_bus` is rejected.
- R3: On the root bus, only device/function 0 is accepted. Root-bus accesses do not depend on `link_up` or `bridge_en`.
- R4: On a bus whose primary bus equals `root_bus` (and that is not the root bus), only device/function 0 is accepted.
- R5: While `bridge_en` is low, every access to a bus other than `root_bus` is rejected.
- R6: `bridge_info` carries the ECAM_SIZE parameter in bits 18:16 and zeros elsewhere. A bus number above ECAM_SIZE is rejected, and bus ECAM_SIZE itself is accepted.
- R7: A rejected access never pulses `fwd_valid`. In the cycle after the handshake, `rsp_valid`=1, `rsp_reject`=1 and `rsp_rdata`=0xFFFFFFFF; this holds for reads and for writes.
- R8: An accepted access pulses `fwd_valid` for one cycle, one cycle after the handshake, with its write flag and write data. One cycle after `cpl_valid` is seen, `rsp_valid`=1, `rsp_reject`=0 and `rsp_rdata` equals `cpl_rdata`.
- R9: The timeout counts from the `fwd_valid` cycle, which is the first waiting cycle. If `cpl_valid` has not appeared by the end of the TIMEOUT_CYC-th waiting cycle, the block pulses `timeout_evt` for one cycle and returns a rejected all-ones response in that same cycle. A completion that arrives in the last waiting cycle still wins.
- R10: `req_ready` is high only when idle. It goes low from the cycle after a handshake through the response cycle, and it is high again the cycle after the response.
- R11: After reset, `req_ready`=1 and `rsp_valid`, `fwd_valid` and `timeout_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Target device/function |
| req_reg | input | REG_W | Register offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_primary | input | BUS_W | Primary bus number of the target bus |
| root_bus | input | BUS_W | Root bus number |
| link_up | input | 1 | Link is up |
| bridge_en | input | 1 | Bridge enable |
| fwd_valid | output | 1 | One-cycle pulse issuing an accepted access |
| fwd_addr | output | ADDR_W | Window address of the access |
| fwd_write | output | 1 | Write flag of the access |
| fwd_wdata | output | DATA_W | Write data of the access |
| cpl_valid | input | 1 | Completion for the outstanding access |
| cpl_rdata | input | DATA_W | Completion read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_reject | output | 1 | Response is a reject or a timeout |
| rsp_addr | output | ADDR_W | Window address (0 on filter reject) |
| rsp_rdata | output | DATA_W | Read data, all ones on reject |
| timeout_evt | output | 1 | One-cycle completion-timeout event |
| bridge_info | output | 32 | Bridge information word with the ECAM size field |

## Verification
The bench builds the block with ECAM_SIZE = 5 and TIMEOUT_CYC = 8. A last valid bus of 5 puts both sides of the bus-range limit (5 accepted, 6 and 255 rejected) among ordinary table vectors. The short timeout makes both a full expiry and a completion in the final waiting cycle cheap to reach. A directed case also moves the root bus to 2, which shows that the single-device and link gating follow the `root_bus` input and are not fixed to bus 0.

// File: rtl/ecam_cfg_decoder.sv
module ecam_cfg_decoder #(
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8,
  parameter int REG_W = 12,
  parameter int DATA_W = 32,
  parameter logic [2:0] ECAM_SIZE = 3'd7,
  parameter int TIMEOUT_CYC = 1024,
  localparam int ADDR_W = BUS_W + DEVFN_W + REG_W,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BUS_W-1:0]  req_primary,
  input  logic [BUS_W-1:0]  root_bus,
  input  logic              link_up,
  input  logic              bridge_en,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic              cpl_valid,
  input  logic [DATA_W-1:0] cpl_rdata,
  output logic              rsp_valid,
  output logic              rsp_reject,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              timeout_evt,
  output logic [31:0]       bridge_info
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP} state_t;
  state_t state;
  logic [CNT_W-1:0] cnt;

  wire fire     = req_valid && req_ready;
  wire on_root  = req_bus == root_bus;
  wire beyond   = req_bus > BUS_W'(ECAM_SIZE);
  wire down_blk = !on_root && (!link_up || !bridge_en);
  wire fn_blk   = (on_root || req_primary == root_bus) && (req_devfn != '0);
  wire refuse   = beyond || down_blk || fn_blk;

  assign req_ready   = state == S_IDLE;
  assign bridge_info = {13'd0, ECAM_SIZE, 16'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      fwd_valid   <= 1'b0;
      fwd_addr    <= '0;
      fwd_write   <= 1'b0;
      fwd_wdata   <= '0;
      rsp_valid   <= 1'b0;
      rsp_reject  <= 1'b0;
      rsp_addr    <= '0;
      rsp_rdata   <= '0;
      timeout_evt <= 1'b0;
    end else begin
      fwd_valid   <= 1'b0;
      rsp_valid   <= 1'b0;
      timeout_evt <= 1'b0;
      case (state)
        S_IDLE: if (fire) begin
          if (refuse) begin
            state      <= S_RESP;
            rsp_valid  <= 1'b1;
            rsp_reject <= 1'b1;
            rsp_rdata  <= '1;
            rsp_addr   <= '0;
          end else begin
            state     <= S_WAIT;
            fwd_valid <= 1'b1;
            fwd_addr  <= {req_bus, req_devfn, req_reg};
            fwd_write <= req_write;
            fwd_wdata <= req_wdata;
            cnt       <= '0;
          end
        end
        S_WAIT: begin
          if (cpl_valid) begin
            state      <= S_RESP;
            rsp_valid  <= 1'b1;
            rsp_reject <= 1'b0;
            rsp_rdata  <= cpl_rdata;
            rsp_addr   <= fwd_addr;
          end else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
            state       <= S_RESP;
            rsp_valid   <= 1'b1;
            rsp_reject  <= 1'b1;
            rsp_rdata   <= '1;
            rsp_addr    <= fwd_addr;
            timeout_evt <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecam_cfg_decoder_chk.sv
module ecam_cfg_decoder_chk #(
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8,
  parameter int REG_W = 12,
  parameter int DATA_W = 32,
  parameter logic [2:0] ECAM_SIZE = 3'd7,
  localparam int ADDR_W = BUS_W + DEVFN_W + REG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BUS_W-1:0]  req_bus,
  input logic [DEVFN_W-1:0] req_devfn,
  input logic [REG_W-1:0]  req_reg,
  input logic [BUS_W-1:0]  req_primary,
  input logic [BUS_W-1:0]  root_bus,
  input logic              link_up,
  input logic              bridge_en,
  input logic              fwd_valid,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              rsp_valid,
  input logic              rsp_reject,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              timeout_evt
);

  wire fire = req_valid && req_ready;

  AST_FWD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire ##1 fwd_valid) |-> fwd_addr == {$past(req_bus), $past(req_devfn), $past(req_reg)}); // R1
  AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_bus != root_bus && !link_up) |=> (rsp_valid && rsp_reject && !fwd_valid)); // R2
  AST_ROOT_DEVFN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_bus == root_bus && req_devfn != '0) |=> (rsp_reject && !fwd_valid)); // R3
  AST_BELOW_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_primary == root_bus && req_devfn != '0) |=> !fwd_valid); // R4
  AST_BRIDGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_bus != root_bus && !bridge_en) |=> !fwd_valid); // R5
  AST_BUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_bus > BUS_W'(ECAM_SIZE)) |=> !fwd_valid); // R6
  AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_reject) |-> rsp_rdata == '1); // R7
  AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid); // R8
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (rsp_valid && rsp_reject) ##1 !timeout_evt); // R9
  AST_BUSY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10

endmodule

bind ecam_cfg_decoder ecam_cfg_decoder_chk #(
  .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .REG_W(REG_W), .DATA_W(DATA_W), .ECAM_SIZE(ECAM_SIZE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg),
  .req_primary(req_primary), .root_bus(root_bus), .link_up(link_up),
  .bridge_en(bridge_en), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
  .rsp_valid(rsp_valid), .rsp_reject(rsp_reject), .rsp_rdata(rsp_rdata),
  .timeout_evt(timeout_evt)
);

// File: tb/ecam_cfg_decoder_tb.sv
module ecam_cfg_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam logic [2:0] ESZ = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, link_up = 1'b0, bridge_en = 1'b0, cpl_valid = 1'b0;
  logic [7:0] req_bus = '0, req_devfn = '0, req_primary = '0, root_bus = '0;
  logic [11:0] req_reg = '0;
  logic [31:0] req_wdata = '0, cpl_rdata = '0;
  logic req_ready, fwd_valid, fwd_write, rsp_valid, rsp_reject, timeout_evt;
  logic [27:0] fwd_addr, rsp_addr;
  logic [31:0] fwd_wdata, rsp_rdata, bridge_info;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecam_cfg_decoder #(.ECAM_SIZE(ESZ), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg), .req_write(req_write),
    .req_wdata(req_wdata), .req_primary(req_primary), .root_bus(root_bus),
    .link_up(link_up), .bridge_en(bridge_en), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_wdata(fwd_wdata), .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata),
    .rsp_valid(rsp_valid), .rsp_reject(rsp_reject), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata),
    .timeout_evt(timeout_evt), .bridge_info(bridge_info));

  // {bus, devfn, primary, link_up, bridge_en, write, expect_accept}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {8'd0,   8'd0,   8'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'd0,   8'd8,   8'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd1,   8'd0,   8'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'd1,   8'd1,   8'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd2,   8'd9,   8'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'd1,   8'd0,   8'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd3,   8'd0,   8'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd5,   8'd0,   8'd4, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'd6,   8'd0,   8'd5, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd1,   8'd0,   8'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'd255, 8'd0,   8'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd4,   8'd255, 8'd3, 1'b1, 1'b1, 1'b1, 1'b1}
  };
  localparam string VTAG [NV] = '{"R3", "R3", "R4", "R4", "R1", "R2", "R5", "R6", "R6", "R7", "R6", "R8"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] df, input logic [7:0] pr,
                      input logic [11:0] rg, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_bus = b; req_devfn = df; req_primary = pr; req_reg = rg;
    req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 fwd_valid", {31'd0, fwd_valid}, 32'd0);
    chk("R11 timeout", {31'd0, timeout_evt}, 32'd0);
    chk("R6 bridge_info", bridge_info, 32'h0005_0000);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] b, df, pr;
      logic [11:0] rg;
      logic [31:0] wd, cd;
      logic acc;
      b = VEC[i][27:20]; df = VEC[i][19:12]; pr = VEC[i][11:4];
      link_up = VEC[i][3]; bridge_en = VEC[i][2]; acc = VEC[i][0];
      rg = 12'(i * 68 + 3);
      wd = 32'hA500_0000 + 32'(i);
      cd = 32'h1234_0000 ^ 32'(i);
      send(b, df, pr, rg, VEC[i][1], wd);
      chk({VTAG[i], " fwd_valid"}, {31'd0, fwd_valid}, {31'd0, acc});
      chk("R10 ready low", {31'd0, req_ready}, 32'd0);
      if (acc) begin
        chk("R1 fwd_addr", {4'd0, fwd_addr}, {4'd0, b, df, rg});
        chk("R8 fwd_write", {31'd0, fwd_write}, {31'd0, VEC[i][1]});
        chk("R8 fwd_wdata", fwd_wdata, wd);
        cpl_valid = 1'b1; cpl_rdata = cd;
        @(posedge clk); @(negedge clk);
        cpl_valid = 1'b0;
        chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk("R8 rsp_reject", {31'd0, rsp_reject}, 32'd0);
        chk("R8 rsp_rdata", rsp_rdata, cd);
        chk("R1 rsp_addr", {4'd0, rsp_addr}, {4'd0, b, df, rg});
      end else begin
        chk({VTAG[i], " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk("R7 rsp_reject", {31'd0, rsp_reject}, 32'd1);
        chk("R7 rsp_rdata", rsp_rdata, 32'hFFFF_FFFF);
      end
      @(negedge clk);
      chk("R10 ready back", {31'd0, req_ready}, 32'd1);
    end

    // R9 full expiry
    link_up = 1'b1; bridge_en = 1'b1;
    send(8'd2, 8'd0, 8'd1, 12'h10, 1'b0, 32'd0);
    chk("R9 issued", {31'd0, fwd_valid}, 32'd1);
    for (int k = 0; k < TMO - 1; k++) begin
      @(negedge clk);
      chk("R9 no early timeout", {31'd0, timeout_evt | rsp_valid}, 32'd0);
      chk("R10 ready held low", {31'd0, req_ready}, 32'd0);
    end
    @(negedge clk);
    chk("R9 timeout_evt", {31'd0, timeout_evt}, 32'd1);
    chk("R9 rsp reject", {30'd0, rsp_valid, rsp_reject}, 32'd3);
    chk("R9 rsp_rdata", rsp_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 single pulse", {31'd0, timeout_evt}, 32'd0);

    // R9 completion in the last waiting cycle wins
    send(8'd2, 8'd0, 8'd1, 12'h20, 1'b0, 32'd0);
    for (int k = 0; k < TMO - 1; k++) @(negedge clk);
    cpl_valid = 1'b1; cpl_rdata = 32'hCAFE_F00D;
    @(negedge clk);
    cpl_valid = 1'b0;
    chk("R9 late cpl no timeout", {31'd0, timeout_evt}, 32'd0);
    chk("R9 late cpl accepted", {30'd0, rsp_valid, rsp_reject}, 32'd2);
    chk("R9 late cpl data", rsp_rdata, 32'hCAFE_F00D);

    // R3 R2 with root bus moved to 2
    @(negedge clk);
    root_bus = 8'd2; link_up = 1'b0; bridge_en = 1'b0;
    send(8'd2, 8'd1, 8'd0, 12'h0, 1'b0, 32'd0);
    chk("R3 root2 devfn1", {30'd0, fwd_valid, rsp_reject}, 32'd1);
    @(negedge clk);
    send(8'd2, 8'd0, 8'd0, 12'h4, 1'b0, 32'd0);
    chk("R3 root2 devfn0 link down", {31'd0, fwd_valid}, 32'd1);
    cpl_valid = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
    @(negedge clk);
    send(8'd0, 8'd0, 8'd0, 12'h4, 1'b0, 32'd0);
    chk("R2 bus0 off-root link down", {30'd0, fwd_valid, rsp_reject}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule